// File: doc/BRIEF.md
# Vectored Interrupt Request Tracker

This block keeps the interrupt state of one processor core for 256 numbered vectors. It holds three bit vectors of 256 bits each. The pending set records vectors that have been raised. The in-service set records vectors the core is handling. The mask set decides which vectors may become pending. Interrupt sources raise a vector number through a valid/ready request stream. The block always shows the highest-numbered pending vector on a valid/ready output stream. A handshake on that output moves the shown vector from pending to in-service. An end-of-interrupt pulse retires the highest-numbered in-service vector.

A 32-bit register port reads the three sets and writes the mask set. The port answers only while the global port-enable input is high. A single-cycle acknowledge carries an error flag for accesses that are refused. The request stream never applies back-pressure: `req_ready` is always high, so every cycle with `req_valid` high is one request. The output stream holds `pend_vector` stable for as long as the pending set does not change. `pend_ready` may be held high; each cycle in which both valid and ready are high acknowledges one vector.

Top module: `vec_irq_tracker`

## Requirements
- R1: Vector v lives in group v>>3, at bit v&7 of that group. Register word w of each set holds vectors 32w to 32w+31, with vector 32w+b at data bit b. Word address = region*8 + w, where region 0 = pending (read-only), 1 = in-service (read-only) and 2 = mask (read/write).
- R2: A request for a vector below 16 changes no state and raises `req_err` for exactly the cycle after the request.
- R3: A request for a vector whose mask bit is 0 is dropped: no pending bit is set and no error is raised.
- R4: Repeated requests for a vector that is already pending merge into one pending bit, so a single acknowledge retires all of them.
- R5: `pend_vector` is the highest-numbered pending vector, and `pend_valid` is low when nothing is pending.
- R6: A handshake (`pend_valid` and `pend_ready` both high) clears the pending bit of `pend_vector` and sets its in-service bit at the same clock edge.
- R7: An `eoi` pulse clears the highest-numbered in-service bit. With no in-service bit set, it has no effect.
- R8: With `port_enable` low, every read or write is refused with `reg_err`. A write with any byte-enable bit low is refused. A refused write changes nothing.
- R9: A write to the pending or in-service region, or any access beyond region 2, is refused with `reg_err`. Refused accesses and all writes return `reg_rdata` = 0. `reg_ack` and the response follow an access by one cycle.
- R10: After reset, the pending and in-service sets are all zero and the mask set is all ones.
- R11: When a request for vector v and a handshake of v fall in the same cycle, v ends up both in service and pending. When `eoi` and a handshake fall in the same cycle, the in-service bit being set wins over the bit being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, always 1 |
| req_vector | input | 8 | Requested vector number |
| req_err | output | 1 | Reserved-vector refusal, one cycle after the request |
| pend_valid | output | 1 | A vector is pending |
| pend_ready | input | 1 | Acknowledge the shown vector |
| pend_vector | output | 8 | Highest-numbered pending vector |
| eoi | input | 1 | End-of-interrupt pulse |
| port_enable | input | 1 | Global enable of the register port |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables |
| reg_ack | output | 1 | Access response strobe |
| reg_err | output | 1 | Access refused |
| reg_rdata | output | 32 | Read data |

## Verification
Two collisions are tested. In the first, a new request for the vector shown on the output lands in the same cycle as its handshake. In the second, an end-of-interrupt lands in the same cycle as a handshake of the vector being retired. Both are provoked by driving `req_valid` or `eoi` together with `pend_ready` at a single edge. Each is judged by reading the pending and in-service words back through the register port and by observing `pend_valid`: the first must leave the vector in both sets, the second must leave it in service only.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RGN_W  = 2;

  typedef enum logic [1:0] {
    RGN_PEND = 2'd0,
    RGN_SERV = 2'd1,
    RGN_MASK = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;
endpackage

// File: rtl/vit_prio_enc.sv
module vit_prio_enc #(
  parameter  int NGRP = 32,
  parameter  int GW   = 8,
  localparam int NB   = NGRP * GW,
  localparam int IW   = $clog2(NB),
  localparam int GWI  = $clog2(GW),
  localparam int GI   = $clog2(NGRP)
) (
  input  logic [NB-1:0] bits_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  function automatic logic [GWI-1:0] top_pos(input logic [GW-1:0] v);
    logic [GWI-1:0] p;
    p = '0;
    for (int b = 0; b < GW; b++) begin
      if (v[b]) p = GWI'(b);
    end
    return p;
  endfunction

  logic [NGRP-1:0] grp_any;
  logic [GWI-1:0]  grp_pos [NGRP];
  logic [GI-1:0]   gsel;

  // Per-group reduction: any bit set and the highest set bit inside the group
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |bits_i[g*GW +: GW];
    assign grp_pos[g] = top_pos(bits_i[g*GW +: GW]);
  end

  // The highest group with any bit set wins
  always_comb begin
    gsel = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) gsel = GI'(g);
    end
  end

  assign hit_o = |grp_any;
  assign idx_o = {gsel, grp_pos[gsel]};

endmodule

// File: rtl/vit_regport.sv
module vit_regport
  import vit_pkg::*;
#(
  parameter  int NVEC   = 256,
  parameter  int ADDR_W = 8,
  localparam int WORDS  = NVEC / WORD_W,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int RSEL_W = ADDR_W - IDX_W,
  localparam int BE_W   = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_enable,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [NVEC-1:0]   pend_set,
  input  logic [NVEC-1:0]   serv_set,
  input  logic [NVEC-1:0]   mask_set,
  output logic              mask_we,
  output logic [IDX_W-1:0]  mask_widx,
  output logic [WORD_W-1:0] mask_wdata,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [WORD_W-1:0] reg_rdata
);

  logic [RSEL_W-1:0] rsel;
  logic [IDX_W-1:0]  widx;
  rgn_e              rgn;
  logic [WORD_W-1:0] pend_w, serv_w, mask_w;
  logic              err_d;
  logic [WORD_W-1:0] rdata_d;

  assign rsel = reg_addr[ADDR_W-1:IDX_W];
  assign widx = reg_addr[IDX_W-1:0];

  always_comb begin
    if (rsel == RSEL_W'(RGN_PEND))      rgn = RGN_PEND;
    else if (rsel == RSEL_W'(RGN_SERV)) rgn = RGN_SERV;
    else if (rsel == RSEL_W'(RGN_MASK)) rgn = RGN_MASK;
    else                                rgn = RGN_NONE;
  end

  // Word selection from the three flat sets
  always_comb begin
    pend_w = '0;
    serv_w = '0;
    mask_w = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (widx == IDX_W'(w)) begin
        pend_w = pend_set[w*WORD_W +: WORD_W];
        serv_w = serv_set[w*WORD_W +: WORD_W];
        mask_w = mask_set[w*WORD_W +: WORD_W];
      end
    end
  end

  // Access decode: a write takes precedence over a read in the same cycle
  always_comb begin
    err_d   = 1'b0;
    rdata_d = '0;
    mask_we = 1'b0;
    if (reg_wr) begin
      if (!port_enable || (reg_be != '1) || (rgn != RGN_MASK)) err_d = 1'b1;
      else mask_we = 1'b1;
    end else if (reg_rd) begin
      if (!port_enable || (rgn == RGN_NONE)) begin
        err_d = 1'b1;
      end else begin
        unique case (rgn)
          RGN_PEND: rdata_d = pend_w;
          RGN_SERV: rdata_d = serv_w;
          default:  rdata_d = mask_w;
        endcase
      end
    end
  end

  assign mask_widx  = widx;
  assign mask_wdata = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_wr | reg_rd;
      reg_err   <= err_d;
      reg_rdata <= rdata_d;
    end
  end

  AST_GATED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) && !port_enable |=> reg_ack && reg_err && (reg_rdata == '0)); // R8

  AST_PARTIAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_be != '1) |=> reg_err); // R8

  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_ack && (reg_rdata == '0)); // R9

endmodule

// File: rtl/vec_irq_tracker.sv
module vec_irq_tracker
  import vit_pkg::*;
#(
  parameter  int NVEC    = 256,
  parameter  int GW      = 8,
  parameter  int LOW_RSV = 16,
  parameter  int ADDR_W  = 8,
  localparam int VEC_W   = $clog2(NVEC),
  localparam int NGRP    = NVEC / GW,
  localparam int WORDS   = NVEC / WORD_W,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int BE_W    = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VEC_W-1:0]  req_vector,
  output logic              req_err,
  output logic              pend_valid,
  input  logic              pend_ready,
  output logic [VEC_W-1:0]  pend_vector,
  input  logic              eoi,
  input  logic              port_enable,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [BE_W-1:0]   reg_be,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [WORD_W-1:0] reg_rdata
);

  logic [NVEC-1:0]   pend_q, serv_q, mask_q;
  logic [NVEC-1:0]   pend_d, serv_d;
  logic              serv_hit;
  logic [VEC_W-1:0]  serv_top;
  logic              req_low, req_take, hs;
  logic              mask_we;
  logic [IDX_W-1:0]  mask_widx;
  logic [WORD_W-1:0] mask_wdata;

  assign req_ready = 1'b1;
  assign req_low   = int'(req_vector) < LOW_RSV;
  assign req_take  = req_valid && !req_low && mask_q[req_vector];
  assign hs        = pend_valid && pend_ready;

  vit_prio_enc #(.NGRP(NGRP), .GW(GW)) u_pend_enc (
    .bits_i (pend_q),
    .hit_o  (pend_valid),
    .idx_o  (pend_vector)
  );

  vit_prio_enc #(.NGRP(NGRP), .GW(GW)) u_serv_enc (
    .bits_i (serv_q),
    .hit_o  (serv_hit),
    .idx_o  (serv_top)
  );

  vit_regport #(.NVEC(NVEC), .ADDR_W(ADDR_W)) u_regport (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_enable (port_enable),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_be      (reg_be),
    .pend_set    (pend_q),
    .serv_set    (serv_q),
    .mask_set    (mask_q),
    .mask_we     (mask_we),
    .mask_widx   (mask_widx),
    .mask_wdata  (mask_wdata),
    .reg_ack     (reg_ack),
    .reg_err     (reg_err),
    .reg_rdata   (reg_rdata)
  );

  // Pending: a handshake clears, then a new request sets (set wins)
  always_comb begin
    pend_d = pend_q;
    if (hs)       pend_d[pend_vector] = 1'b0;
    if (req_take) pend_d[req_vector]  = 1'b1;
  end

  // In-service: end-of-interrupt clears the top, then a handshake sets
  always_comb begin
    serv_d = serv_q;
    if (eoi && serv_hit) serv_d[serv_top]    = 1'b0;
    if (hs)              serv_d[pend_vector] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      serv_q  <= '0;
      mask_q  <= '1;
      req_err <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      serv_q  <= serv_d;
      req_err <= req_valid && req_low;
      for (int w = 0; w < WORDS; w++) begin
        if (mask_we && (mask_widx == IDX_W'(w))) mask_q[w*WORD_W +: WORD_W] <= mask_wdata;
      end
    end
  end

  AST_LOW_VEC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_low |=> req_err); // R2

  AST_LOW_VEC_NOSTATE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_low && !pend_ready && !eoi |=> $stable(pend_q) && $stable(serv_q)); // R2

  AST_DROP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_low && !mask_q[req_vector] && !pend_q[req_vector]
    |=> !pend_q[$past(req_vector)] && !req_err); // R3

  AST_PEND_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> pend_q[pend_vector] && (int'(pend_vector) >= LOW_RSV)); // R5

  AST_HS_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> serv_q[$past(pend_vector)]); // R6

  AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && !hs && (serv_q == '0) |=> (serv_q == '0)); // R7

endmodule

// File: tb/vec_irq_tracker_tb.sv
module vec_irq_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vector = '0;
  logic        req_err;
  logic        pend_valid;
  logic        pend_ready = 1'b0;
  logic [7:0]  pend_vector;
  logic        eoi = 1'b0;
  logic        port_enable = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '1;
  logic        reg_ack;
  logic        reg_err;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] exp_data_q[$];
  logic        exp_err_q[$];
  string       exp_tag_q[$];

  always #2.5 clk = ~clk;

  vec_irq_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector), .req_err(req_err),
    .pend_valid(pend_valid), .pend_ready(pend_ready), .pend_vector(pend_vector),
    .eoi(eoi), .port_enable(port_enable),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_pend(input string tag, input logic v, input logic [7:0] vec);
    chk({tag, " valid"}, {31'd0, pend_valid}, {31'd0, v});
    if (v) chk({tag, " vector"}, {24'd0, pend_vector}, {24'd0, vec});
  endtask

  // Monitor: pops one expected response for every reg_ack
  always @(negedge clk) begin
    if (rst_n && reg_ack) begin
      if (exp_data_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9: unexpected response, actual %h expected none", reg_rdata);
      end else begin
        automatic logic [31:0] ed = exp_data_q.pop_front();
        automatic logic        ee = exp_err_q.pop_front();
        automatic string       et = exp_tag_q.pop_front();
        chk({et, " rdata"}, reg_rdata, ed);
        chk({et, " err"}, {31'd0, reg_err}, {31'd0, ee});
      end
    end
  end

  task automatic do_req(input logic [7:0] v);
    req_valid = 1'b1; req_vector = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ack();
    pend_ready = 1'b1;
    @(negedge clk);
    pend_ready = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] ed, input logic ee, input string tag);
    exp_data_q.push_back(ed); exp_err_q.push_back(ee); exp_tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                    input logic ee, input string tag);
    exp_data_q.push_back('0); exp_err_q.push_back(ee); exp_tag_q.push_back(tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '1;
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk_pend("R10", 1'b0, 8'd0);
    rd(8'd16, 32'hFFFF_FFFF, 1'b0, "R10 mask word0");
    rd(8'd23, 32'hFFFF_FFFF, 1'b0, "R10 mask word7");
    rd(8'd0, 32'h0, 1'b0, "R10 pending word0");

    // R2 reserved vector
    do_req(8'd3);
    chk("R2 req_err", {31'd0, req_err}, 32'd1);
    chk_pend("R2", 1'b0, 8'd0);
    rd(8'd0, 32'h0, 1'b0, "R2 pending word0");

    // R5 / R1 priority and layout
    do_req(8'd40);
    chk("R3 no err on good request", {31'd0, req_err}, 32'd0);
    chk_pend("R5 single", 1'b1, 8'd40);
    do_req(8'd100);
    chk_pend("R5 higher", 1'b1, 8'd100);
    do_req(8'd50);
    chk_pend("R5 lower later", 1'b1, 8'd100);
    rd(8'd1, 32'h0004_0100, 1'b0, "R1 pending word1");
    rd(8'd3, 32'h0000_0010, 1'b0, "R1 pending word3");

    // R4 coalesce, R6 handshake
    do_req(8'd100);
    do_ack();
    chk_pend("R4 after one ack", 1'b1, 8'd50);
    rd(8'd3, 32'h0, 1'b0, "R4 pending word3");
    rd(8'd11, 32'h0000_0010, 1'b0, "R6 service word3");
    do_ack();
    chk_pend("R6 next", 1'b1, 8'd40);
    do_ack();
    chk_pend("R6 empty", 1'b0, 8'd0);
    rd(8'd9, 32'h0004_0100, 1'b0, "R6 service word1");

    // R7 end-of-interrupt order
    do_eoi();
    rd(8'd11, 32'h0, 1'b0, "R7 eoi top");
    rd(8'd9, 32'h0004_0100, 1'b0, "R7 lower kept");
    do_eoi();
    rd(8'd9, 32'h0000_0100, 1'b0, "R7 second");
    do_eoi();
    do_eoi();
    rd(8'd9, 32'h0, 1'b0, "R7 empty eoi");
    chk_pend("R7 empty eoi", 1'b0, 8'd0);

    // R3 masked vector
    wr(8'd18, 32'hFFFF_FFFE, 4'hF, 1'b0, "R3 mask write");
    do_req(8'd64);
    chk("R3 no err", {31'd0, req_err}, 32'd0);
    chk_pend("R3 dropped", 1'b0, 8'd0);
    rd(8'd2, 32'h0, 1'b0, "R3 pending word2");

    // R8 / R9 port rules
    port_enable = 1'b0;
    rd(8'd18, 32'h0, 1'b1, "R8 gated read");
    wr(8'd18, 32'hFFFF_FFFF, 4'hF, 1'b1, "R8 gated write");
    port_enable = 1'b1;
    wr(8'd18, 32'hFFFF_FFFF, 4'h7, 1'b1, "R8 partial write");
    rd(8'd18, 32'hFFFF_FFFE, 1'b0, "R8 mask unchanged");
    wr(8'd1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R9 write read-only");
    rd(8'd1, 32'h0, 1'b0, "R9 read-only unchanged");
    rd(8'd30, 32'h0, 1'b1, "R9 unhandled read");
    wr(8'd30, 32'h1234_5678, 4'hF, 1'b1, "R9 unhandled write");

    // R11 request and handshake of the same vector together
    do_req(8'd200);
    chk_pend("R11 setup", 1'b1, 8'd200);
    req_valid = 1'b1; req_vector = 8'd200; pend_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; pend_ready = 1'b0;
    chk_pend("R11 still pending", 1'b1, 8'd200);
    rd(8'd14, 32'h0000_0100, 1'b0, "R11 in service");
    rd(8'd6, 32'h0000_0100, 1'b0, "R11 pending word6");

    // R11 eoi and handshake together
    eoi = 1'b1; pend_ready = 1'b1;
    @(negedge clk);
    eoi = 1'b0; pend_ready = 1'b0;
    chk_pend("R11 eoi+ack", 1'b0, 8'd0);
    rd(8'd14, 32'h0000_0100, 1'b0, "R11 set wins");
    do_eoi();
    rd(8'd14, 32'h0, 1'b0, "R7 final retire");

    repeat (2) @(negedge clk);
    chk("R9 all responses seen", exp_data_q.size(), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule